// File: doc/BRIEF.md
# Port Function and NMI Edge Control Register

This block holds one 8-bit control register for an 8-pin general-purpose port of a small microcontroller. The register decides whether two of the pins serve as external interrupt inputs and whether two others are handed to the bus-release logic. It also sets which edge of the nonmaskable interrupt pin raises a request. Software writes the register through a one-cycle write strobe and reads it back at any time through a combinational read path.

Per pin, the block combines the data-direction and data register bits supplied by the port with the register contents. From these it produces the output enable, the value to drive, a mask of pins taken over by an alternate function, and the value the CPU sees when it reads the port. The NMI pin passes through a two-flop synchroniser. A one-clock request pulse is raised on the selected edge. A system reset or hardware standby returns the register to its initial value. Nothing else reinitialises it, so its contents survive software standby.

Top module: `portctl_nmi`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `ctl_rdata` reads 8'h87.
- R2: While `hw_stby` is 1 at a clock edge, the register is set to 8'h87, and a write in the same cycle is discarded.
- R3: Bit 7 of `ctl_rdata` always reads 1, whatever value was written to bit 7.
- R4: A write with `ctl_we`=1 (and `hw_stby`=0) stores `ctl_wdata[6:0]`, which is visible on `ctl_rdata[6:0]` from the following cycle. Bits 2..0 are plain storage.
- R5: When register bit 6 is 1, pin 6 is an IRQ1 input. `pin_alt[6]`=1, `pin_oe[6]`=0 whatever `port_ddr[6]` holds, and `irq1_lvl` follows `pin_in[6]`. When bit 6 is 0, `irq1_lvl` is 1 and pin 6 is ordinary I/O.
- R6: Register bit 5 does the same for pin 5 and `irq0_lvl`.
- R7: `pin_out` equals `port_dr`. `port_rd[i]` returns `port_dr[i]` when `pin_oe[i]`=1, and returns `pin_in[i]` otherwise, which includes pins taken over as IRQ inputs.
- R8: `brel_en` is 1 only when register bit 3 is 1 and `mode` is 1, 2, 3 or 4. When it is 1, pins 2 and 3 have `pin_alt`=1 and `pin_oe`=0. In every other mode those pins remain ordinary I/O.
- R9: With register bit 4 at 0, a high-to-low change on `nmi_pin` gives exactly one `nmi_req` pulse of one clock, high in the cycle after the second clock edge that sees the new level. A rising change gives no pulse.
- R10: With register bit 4 at 1, a low-to-high change on `nmi_pin` gives the same single pulse, and a falling change gives none.
- R11: `nmi_req` is 0 in every cycle in which `hw_stby` is 1.
- R12: Without a write, `hw_stby` or reset, the register keeps its value across any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| hw_stby | input | 1 | Hardware standby; reinitialises the register |
| mode | input | 3 | Synchronised operating mode; 1..4 are expanded modes |
| ctl_we | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Register read data |
| port_ddr | input | 8 | Data-direction bits, 1 = output |
| port_dr | input | 8 | Port data register bits |
| pin_in | input | 8 | Live pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin drive value |
| pin_alt | output | 8 | Pins taken over by an alternate function |
| port_rd | output | 8 | Value returned by a port data read |
| irq0_lvl | output | 1 | IRQ0 routing: pin 5 level when enabled, else 1 |
| irq1_lvl | output | 1 | IRQ1 routing: pin 6 level when enabled, else 1 |
| brel_en | output | 1 | Bus-release function active on pins 2 and 3 |
| nmi_pin | input | 1 | Asynchronous nonmaskable interrupt pin |
| nmi_req | output | 1 | One-clock NMI request pulse |

## Verification
The pin-function logic is driven with random direction, data and pin levels under every mode value and random register writes. This separates a forced-off output enable from a direction-controlled one, and a readback from the pin from a readback from the data register. Directed NMI sequences apply both edge directions under both polarity settings. They show whether the pulse appears only on the selected edge and only once. One case repeats the falling edge during hardware standby, and another case keeps the register idle to confirm that it holds its value. A write made together with standby shows that the restore takes priority.

// File: rtl/portctl_nmi.sv
module portctl_nmi #(
  parameter logic [7:0] RST_VAL = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_stby,
  input  logic [2:0] mode,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic [7:0] port_ddr,
  input  logic [7:0] port_dr,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_out,
  output logic [7:0] pin_alt,
  output logic [7:0] port_rd,
  output logic       irq0_lvl,
  output logic       irq1_lvl,
  output logic       brel_en,
  input  logic       nmi_pin,
  output logic       nmi_req
);
  localparam int IRQ1_BIT = 6;
  localparam int IRQ0_BIT = 5;
  localparam int EDGE_BIT = 4;
  localparam int BREL_BIT = 3;

  logic [6:0] ctl_q;
  logic [2:0] nmi_sh;
  logic       expanded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= RST_VAL[6:0];
    else if (hw_stby) ctl_q <= RST_VAL[6:0];
    else if (ctl_we)  ctl_q <= ctl_wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_sh <= '0;
    else        nmi_sh <= {nmi_sh[1:0], nmi_pin};
  end

  assign ctl_rdata = {1'b1, ctl_q};
  assign expanded  = (mode >= 3'd1) && (mode <= 3'd4);
  assign brel_en   = ctl_q[BREL_BIT] & expanded;

  always_comb begin
    pin_alt    = '0;
    pin_alt[6] = ctl_q[IRQ1_BIT];
    pin_alt[5] = ctl_q[IRQ0_BIT];
    pin_alt[3] = brel_en;
    pin_alt[2] = brel_en;
  end

  assign pin_oe   = port_ddr & ~pin_alt;
  assign pin_out  = port_dr;
  assign port_rd  = (pin_oe & port_dr) | (~pin_oe & pin_in);
  assign irq1_lvl = ctl_q[IRQ1_BIT] ? pin_in[6] : 1'b1;
  assign irq0_lvl = ctl_q[IRQ0_BIT] ? pin_in[5] : 1'b1;

  assign nmi_req = ~hw_stby & (ctl_q[EDGE_BIT] ? (nmi_sh[1] & ~nmi_sh[2])
                                               : (~nmi_sh[1] & nmi_sh[2]));
endmodule

// File: rtl/portctl_nmi_chk.sv
module portctl_nmi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_stby,
  input logic [2:0] mode,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic [7:0] pin_oe,
  input logic       brel_en,
  input logic       nmi_req
);
  a_r2_stby_restores: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> ctl_rdata == 8'h87);
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !hw_stby) |=> ctl_rdata[6:0] == $past(ctl_wdata[6:0]));
  a_r5_irq1_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6] |-> !pin_oe[6]);
  a_r6_irq0_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[5] |-> !pin_oe[5]);
  a_r8_single_chip: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode > 3'd4) |-> !brel_en);
  a_r11_stby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> !nmi_req);
  a_r12_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !hw_stby) |=> $stable(ctl_rdata));
endmodule

bind portctl_nmi portctl_nmi_chk u_chk (.*);

// File: tb/portctl_nmi_tb.sv
module portctl_nmi_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, hw_stby, ctl_we, nmi_pin;
  logic [2:0] mode;
  logic [7:0] ctl_wdata, port_ddr, port_dr, pin_in;
  logic [7:0] ctl_rdata, pin_oe, pin_out, pin_alt, port_rd;
  logic       irq0_lvl, irq1_lvl, brel_en, nmi_req;

  portctl_nmi u_dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_ctl;
  logic [2:0] m_hist;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl  = 8'h87;
      m_hist = 3'b000;
    end else begin
      if (hw_stby)     m_ctl = 8'h87;
      else if (ctl_we) m_ctl = {1'b1, ctl_wdata[6:0]};
      m_hist = {m_hist[1:0], nmi_pin};
    end
  end

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic       ex = (mode >= 3'd1) && (mode <= 3'd4);
    logic       br = m_ctl[3] && ex;
    logic [7:0] alt = {1'b0, m_ctl[6], m_ctl[5], 1'b0, br, br, 2'b00};
    logic [7:0] oe = port_ddr & ~alt;
    logic [7:0] rd;
    logic       pulse;
    for (int i = 0; i < 8; i++) rd[i] = oe[i] ? port_dr[i] : pin_in[i];
    pulse = !hw_stby && (m_ctl[4] ? (m_hist[1] && !m_hist[2]) : (!m_hist[1] && m_hist[2]));
    check("R3", ctl_rdata[7], 1'b1);
    check("R4", ctl_rdata[6:0], m_ctl[6:0]);
    check("R8", brel_en, br);
    check("R8", pin_alt, alt);
    check("R5", pin_oe, oe);
    check("R7", pin_out, port_dr);
    check("R7", port_rd, rd);
    check("R5", irq1_lvl, m_ctl[6] ? pin_in[6] : 1'b1);
    check("R6", irq0_lvl, m_ctl[5] ? pin_in[5] : 1'b1);
    check(m_ctl[4] ? "R10" : "R9", nmi_req, pulse);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    tick();
    ctl_we = 1'b0;
  endtask

  function automatic int count_pulses_dummy();
    return 0;
  endfunction

  task automatic nmi_edge(logic lvl, output int pulses);
    pulses = 0;
    nmi_pin = lvl;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (nmi_req) pulses++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int p;
    rst_n = 1'b0; hw_stby = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
    mode = 3'd7; port_ddr = 8'hFF; port_dr = 8'h5A; pin_in = 8'hC3; nmi_pin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1", ctl_rdata, 8'h87);

    wr(8'h00);
    check("R3", ctl_rdata, 8'h80);
    wr(8'h7F);
    check("R4", ctl_rdata, 8'hFF);
    check("R5", pin_oe[6], 1'b0);
    check("R6", pin_oe[5], 1'b0);
    check("R7", port_rd[6], pin_in[6]);
    check("R8", brel_en, 1'b0);
    mode = 3'd2; tick();
    check("R8", brel_en, 1'b1);
    check("R8", pin_oe[3:2], 2'b00);

    ctl_we = 1'b1; ctl_wdata = 8'h00; hw_stby = 1'b1;
    tick();
    ctl_we = 1'b0; hw_stby = 1'b0;
    check("R2", ctl_rdata, 8'h87);

    wr(8'h2A);
    repeat (5) tick();
    check("R12", ctl_rdata, 8'hAA);

    wr(8'h07);
    nmi_edge(1'b1, p);
    nmi_edge(1'b0, p); check("R9", p, 1);
    nmi_edge(1'b1, p); check("R9", p, 0);
    wr(8'h17);
    nmi_edge(1'b0, p); check("R10", p, 0);
    nmi_edge(1'b1, p); check("R10", p, 1);
    wr(8'h07);
    hw_stby = 1'b1;
    nmi_edge(1'b0, p); check("R11", p, 0);
    hw_stby = 1'b0;
    tick();

    for (int c = 0; c < 4000; c++) begin
      ctl_we    = ($urandom % 4) == 0;
      ctl_wdata = 8'($urandom);
      hw_stby   = ($urandom % 64) == 0;
      mode      = 3'($urandom);
      port_ddr  = 8'($urandom);
      port_dr   = 8'($urandom);
      pin_in    = 8'($urandom);
      if (($urandom % 5) == 0) nmi_pin = ~nmi_pin;
      tick();
    end

    summary();
    $finish;
  end
endmodule